// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic stage for an 8-bit accumulator datapath. A five-bit operation code chooses one of seventeen operations. The operations combine the accumulator with an operand byte, transform the accumulator alone, or only change a flag. The result is combinational from the inputs and from the stored carry. A separate register holds four condition flags: zero, carry, negative and interrupt.

The flag register loads on the rising clock edge only while the flag write enable is high. The surrounding sequencer therefore decides which cycles commit flags. It can evaluate a result without disturbing the condition state, for example to compute a value that is never stored. Operand fetch, addressing and branching are outside this block. The flag outputs are what a branch unit tests.

Top module: `acc_alu`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, all four flags (flag_z, flag_c, flag_n, flag_i) read 0.
- R2: Op code 0 (add) gives result = (acc_in + operand) mod 256. With flag_we high, carry takes bit 8 of the 9-bit sum.
- R3: Op code 1 (nor) gives result = bitwise NOT of (acc_in OR operand). With flag_we high, carry is cleared.
- R4: For op codes 0 to 12, a cycle with flag_we high sets flag_z when the result is 0x00 and copies result bit 7 into flag_n.
- R5: Op code 2 (increment) and op code 3 (decrement) wrap modulo 256 and leave carry unchanged.
- R6: Op code 4 (complement) gives NOT acc_in and clears carry. Op code 5 (negate) gives the two's complement of acc_in and sets carry exactly when acc_in is nonzero.
- R7: Op code 6 (test) outputs acc_in unchanged and leaves carry unchanged. Op code 7 (clear) outputs 0x00 and clears carry.
- R8: Op code 8 (arithmetic right) keeps bit 7. Op code 9 (left) shifts in 0 at bit 0. Op code 10 (logical right) shifts in 0 at bit 7. In each case the bit shifted out goes to carry.
- R9: Op code 11 (rotate left) moves the stored carry into bit 0 and bit 7 into carry. Op code 12 (rotate right) moves the stored carry into bit 7 and bit 0 into carry.
- R10: Op codes 13, 14, 15 and 16 set carry, clear carry, set interrupt and clear interrupt, in that order. They leave every other flag alone and output acc_in. No other op code changes flag_i.
- R11: With flag_we low, no flag changes, whatever the op code.
- R12: Op codes 17 to 31 are undefined. They output acc_in and leave all flags unchanged even with flag_we high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op | input | 5 | Operation code |
| acc_in | input | 8 | Current accumulator value |
| operand | input | 8 | Second operand for add and nor |
| flag_we | input | 1 | Commit flag updates at the next rising edge |
| result | output | 8 | Combinational operation result |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_n | output | 1 | Negative flag |
| flag_i | output | 1 | Interrupt flag |

## Verification
Two things meet in the same cycle during a rotate. The result reads the stored carry, and the flag register overwrites that same carry at the edge that ends the cycle. The bench runs back-to-back rotate and shift sequences with flag_we held high, so each cycle's result depends on the carry the previous cycle committed. The bench model chains that carry arithmetically. A result that used the incoming carry, or a carry that was lost or committed late, would show up as a mismatch on the very next operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_NOR = 5'd1,  OP_INC = 5'd2,  OP_DEC = 5'd3,
    OP_COM = 5'd4,  OP_NEG = 5'd5,  OP_TST = 5'd6,  OP_CLR = 5'd7,
    OP_ASR = 5'd8,  OP_LSL = 5'd9,  OP_LSR = 5'd10, OP_ROL = 5'd11,
    OP_ROR = 5'd12, OP_SEC = 5'd13, OP_CLC = 5'd14, OP_SEI = 5'd15,
    OP_CLI = 5'd16
  } alu_op_e;

  // Operations whose result drives the zero and negative flags
  function automatic logic op_writes_zn(logic [OP_W-1:0] o);
    return o <= OP_ROR;
  endfunction

  function automatic logic op_is_shift(logic [OP_W-1:0] o);
    return (o >= OP_ASR) && (o <= OP_ROR);
  endfunction

  function automatic logic op_defined(logic [OP_W-1:0] o);
    return o <= OP_CLI;
  endfunction
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res,
  output logic             c_new,
  output logic             c_upd
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    res   = a;
    c_new = 1'b0;
    c_upd = 1'b0;
    case (op)
      OP_ADD: begin
        {c_new, res} = {1'b0, a} + {1'b0, b};
        c_upd = 1'b1;
      end
      OP_NOR: begin
        res   = ~(a | b);
        c_upd = 1'b1;
      end
      OP_INC: res = a + ONE;
      OP_DEC: res = a - ONE;
      OP_COM: begin
        res   = ~a;
        c_upd = 1'b1;
      end
      OP_NEG: begin
        res   = (~a) + ONE;
        c_new = |a;
        c_upd = 1'b1;
      end
      OP_TST: res = a;
      OP_CLR: begin
        res   = '0;
        c_upd = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] a,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             c_new
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    res   = a;
    c_new = 1'b0;
    case (op)
      OP_ASR: begin res = {a[MSB], a[MSB:1]};   c_new = a[0];   end
      OP_LSL: begin res = {a[MSB-1:0], 1'b0};   c_new = a[MSB]; end
      OP_LSR: begin res = {1'b0, a[MSB:1]};     c_new = a[0];   end
      OP_ROL: begin res = {a[MSB-1:0], cin};    c_new = a[MSB]; end
      OP_ROR: begin res = {cin, a[MSB:1]};      c_new = a[0];   end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] res,
  input  logic             c_new,
  input  logic             c_upd,
  output logic             z,
  output logic             c,
  output logic             n,
  output logic             i
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z <= 1'b0;
      c <= 1'b0;
      n <= 1'b0;
      i <= 1'b0;
    end else if (we) begin
      if (op_writes_zn(op)) begin
        z <= (res == '0);
        n <= res[WIDTH-1];
      end
      if (c_upd) c <= c_new;
      case (op)
        OP_SEC:  c <= 1'b1;
        OP_CLC:  c <= 1'b0;
        OP_SEI:  i <= 1'b1;
        OP_CLI:  i <= 1'b0;
        default: ;
      endcase
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable({z, c, n, i}));

  p_undef_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !op_defined(op)) |=> $stable({z, c, n, i}));

  p_int_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op != OP_SEI && op != OP_CLI) |=> $stable(i));

  p_sec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op == OP_SEC) |=> c);
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] acc_in,
  input  logic [WIDTH-1:0] operand,
  input  logic             flag_we,
  output logic [WIDTH-1:0] result,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_n,
  output logic             flag_i
);
  logic [WIDTH-1:0] ar_res, sh_res;
  logic             ar_c, ar_upd, sh_c;
  logic             sel_shift;
  logic             c_new, c_upd;

  acc_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .op(op), .a(acc_in), .b(operand),
    .res(ar_res), .c_new(ar_c), .c_upd(ar_upd)
  );

  acc_alu_shift #(.WIDTH(WIDTH)) u_shift (
    .op(op), .a(acc_in), .cin(flag_c),
    .res(sh_res), .c_new(sh_c)
  );

  always_comb begin
    sel_shift = op_is_shift(op);
    if (sel_shift) begin
      result = sh_res;
      c_new  = sh_c;
      c_upd  = 1'b1;
    end else if (op_writes_zn(op)) begin
      result = ar_res;
      c_new  = ar_c;
      c_upd  = ar_upd;
    end else begin
      result = acc_in;
      c_new  = 1'b0;
      c_upd  = 1'b0;
    end
  end

  acc_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .we(flag_we), .op(op),
    .res(result), .c_new(c_new), .c_upd(c_upd),
    .z(flag_z), .c(flag_c), .n(flag_n), .i(flag_i)
  );

  p_tst_passes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_TST) |-> (result == acc_in));

  p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_writes_zn(op)) |=> (flag_z == ($past(result) == '0)));

  p_neg_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_writes_zn(op)) |=> (flag_n == $past(result[WIDTH-1])));
endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] acc_in = '0, operand = '0;
  logic       flag_we = 1'b0;
  logic [7:0] result;
  logic       flag_z, flag_c, flag_n, flag_i;

  int total = 0, bad = 0;
  bit done = 0;
  logic mz = 0, mc = 0, mn = 0, mi = 0;

  always #4 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op(op), .acc_in(acc_in), .operand(operand),
    .flag_we(flag_we), .result(result), .flag_z(flag_z), .flag_c(flag_c),
    .flag_n(flag_n), .flag_i(flag_i)
  );

  function automatic string tag_of(int o);
    case (o)
      0: return "R2/R4";   1: return "R3/R4";
      2, 3: return "R5/R4"; 4, 5: return "R6/R4";
      6, 7: return "R7/R4"; 8, 9, 10: return "R8/R4";
      11, 12: return "R9/R4"; 13, 14, 15, 16: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(int o, logic [7:0] a, logic [7:0] b, logic we);
    logic [7:0] r;
    logic       nz, nc, nn, ni;
    logic [8:0] s;
    string      t;
    t = we ? tag_of(o) : "R11";
    @(negedge clk);
    op = o[4:0]; acc_in = a; operand = b; flag_we = we;
    r = a; nz = mz; nc = mc; nn = mn; ni = mi;
    case (o)
      0: begin s = {1'b0, a} + {1'b0, b}; r = s[7:0]; nc = s[8]; end
      1: begin r = ~(a | b); nc = 0; end
      2: r = a + 8'd1;
      3: r = a - 8'd1;
      4: begin r = ~a; nc = 0; end
      5: begin r = 8'd0 - a; nc = (a != 0); end
      6: r = a;
      7: begin r = 0; nc = 0; end
      8: begin r = {a[7], a[7:1]}; nc = a[0]; end
      9: begin r = {a[6:0], 1'b0}; nc = a[7]; end
      10: begin r = {1'b0, a[7:1]}; nc = a[0]; end
      11: begin r = {a[6:0], mc}; nc = a[7]; end
      12: begin r = {mc, a[7:1]}; nc = a[0]; end
      13: nc = 1;
      14: nc = 0;
      15: ni = 1;
      16: ni = 0;
      default: ;
    endcase
    if (o <= 12) begin nz = (r == 0); nn = r[7]; end
    #1 check(t, "result", result, r);
    @(posedge clk); #1;
    if (we) begin mz = nz; mc = nc; mn = nn; mi = ni; end
    check(t, "flags{zcni}", {flag_z, flag_c, flag_n, flag_i}, {mz, mc, mn, mi});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", "reset flags", {flag_z, flag_c, flag_n, flag_i}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", "flags after release", {flag_z, flag_c, flag_n, flag_i}, 0);

    // R2: exhaustive add
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) step(0, a[7:0], b[7:0], 1);
    // R3: nor, stride over operand
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 5) step(1, a[7:0], b[7:0], 1);
    // R5..R9 with both carry-in values
    for (int o = 2; o <= 12; o++)
      for (int a = 0; a < 256; a++)
        for (int ci = 0; ci < 2; ci++) begin
          step(ci ? 13 : 14, 8'h00, 8'h00, 1);
          step(o, a[7:0], 8'h3c, 1);
        end
    // R9 chained rotates: carry written and read across back-to-back cycles
    for (int k = 0; k < 64; k++) begin
      step(11, 8'h80 ^ k[7:0], 8'h00, 1);
      step(12, 8'h01 ^ k[7:0], 8'h00, 1);
      step(9, 8'hc3, 8'h00, 1);
    end
    // R10 flag ops in varied orders
    for (int k = 0; k < 32; k++) begin
      step(0, 8'hff, k[7:0], 1);
      step(13 + (k % 4), k[7:0], 8'h00, 1);
      step(13 + ((k + 2) % 4), 8'h80, 8'h00, 1);
    end
    // R11 writes disabled
    step(15, 8'h00, 8'h00, 1);
    step(13, 8'h00, 8'h00, 1);
    for (int o = 0; o < 32; o++)
      for (int a = 0; a < 256; a += 17) step(o, a[7:0], 8'hff, 0);
    // R12 undefined codes with writes enabled
    for (int o = 17; o < 32; o++)
      for (int a = 0; a < 256; a += 13) step(o, a[7:0], 8'h55, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule